// File: doc/BRIEF.md
# Character Opcode-Steal Video Fetcher

This block sits on the processor's memory path and turns part of the instruction stream into character graphics. When the processor fetches an opcode from the upper half of the address space, the block reads the RAM byte at the lower-half alias instead. A byte whose bit 6 is set goes to the processor as a normal opcode. A byte whose bit 6 is clear is a character code. The processor is then handed a NOP (0x00), and the block remembers the code, its inversion flag and the current line-within-row count.

On the next refresh cycle the block builds a glyph address from the refresh address and the stored code. It reads the pattern byte from ROM, or from RAM when the address lies above the ROM. It inverts the byte when needed and shifts it out as eight monochrome pixels, most significant bit first. Refresh cycles also drive the maskable interrupt line from bit 6 of the refresh address.

All accesses are one clock long, with strobes qualified by `mem_req`. The RAM and ROM are outside the block and return read data in the same cycle for the addresses it drives. The processor data, interrupt and pixel outputs are registered.

Top module: `charsteal_video`

## Requirements
- R1: After reset, `cpu_rdata` is 0x00, `irq_n` is 1, `pix_out` is 0, and no video fetch is pending; a refresh after reset produces no pixels.
- R2: A read (`mem_req` and `rd_req`) at an address below `ROM_BYTES` returns the ROM byte at the address masked to `ROM_BYTES-1` on `cpu_rdata` in the next cycle.
- R3: A read at or above `ROM_BYTES` that is not a mirrored opcode fetch returns the RAM byte at that address if it is below `RAM_TOP`, else 0xFF.
- R4: An opcode fetch (`opfetch` high) above the ROM with address bit 15 set reads RAM at the address with bit 15 cleared (0xFF where that is at or above `RAM_TOP`); a byte with bit 6 set reaches `cpu_rdata` unchanged.
- R5: If that byte has bit 6 clear, `cpu_rdata` becomes 0x00 and a video fetch becomes pending for the next refresh cycle.
- R6: The glyph address is the refresh address with bits 7:0 cleared, ORed with the byte's bits 5:0 shifted left by 3, ORed with `line_cnt` as sampled in the stealing fetch; if below `ROM_BYTES` the pattern comes from ROM at that address masked to the ROM size.
- R7: If the glyph address is at or above `ROM_BYTES`, the pattern is the RAM byte at the refresh address, or 0xFF if the refresh address is at or above `RAM_TOP`.
- R8: The pattern is inverted when bit 7 of the character byte is 0 and used unchanged when it is 1.
- R9: On each refresh cycle `irq_n` takes bit 6 of the refresh address (low, active, when that bit is 0); it holds its value in all other cycles.
- R10: The pattern's bits appear on `pix_out` from bit 7 down to bit 0, one per clock, the first in the cycle after the refresh; `pix_out` is 0 once they are done, and a refresh with no pending fetch shows nothing.
- R11: A pattern loaded while an earlier one is still shifting replaces the earlier one's remaining pixels at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor address (refresh address during refresh) |
| mem_req | input | 1 | Memory access in this cycle |
| rd_req | input | 1 | The access is a read |
| opfetch | input | 1 | The read is an opcode fetch |
| refresh | input | 1 | The access is a refresh cycle |
| ram_rdata | input | 8 | RAM data for `mem_addr` |
| rom_rdata | input | 8 | ROM data for `rom_addr` |
| line_cnt | input | 3 | Line-within-row count |
| cpu_rdata | output | 8 | Registered data returned to the processor |
| mem_addr | output | ADDR_W | RAM address (alias address on mirrored fetch, refresh address on refresh) |
| rom_addr | output | log2(ROM_BYTES) | ROM address (glyph address on a pending refresh) |
| irq_n | output | 1 | Maskable interrupt request, active low |
| pix_out | output | 1 | Serial pixel stream |

## Verification
The bench builds the block with `ROM_BYTES` = 2048 and `RAM_TOP` = 0x5000. The small ROM means a refresh high byte of 0x08 or more puts the glyph outside ROM, so the RAM fallback of R7 is reached often. The RAM ceiling leaves mirrored fetches, plain reads and refresh addresses at 0x5000 or above, where the open-bus 0xFF value is returned. Random accesses are mixed with directed cases for pattern override, reset with a fetch pending, and the no-RAM fallbacks.

// File: rtl/charsteal_pkg.sv
package charsteal_pkg;
  localparam int BYTE_W   = 8;
  localparam int CHR_W    = 6;
  localparam int LINE_W   = 3;
  localparam int PASS_BIT = 6;
  localparam int INV_BIT  = 7;
  localparam int IRQ_BIT  = 6;
  localparam int CNT_W    = $clog2(BYTE_W);

  typedef struct packed {
    logic              valid;
    logic              inv;
    logic [CHR_W-1:0]  chr;
    logic [LINE_W-1:0] line;
  } vreq_t;
endpackage

// File: rtl/steal_decode.sv
module steal_decode
  import charsteal_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 8192,
  parameter int RAM_TOP   = 17408
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic                        mem_req,
  input  logic                        rd_req,
  input  logic                        opfetch,
  input  logic [BYTE_W-1:0]           ram_rdata,
  input  logic [BYTE_W-1:0]           rom_rdata,
  input  logic [LINE_W-1:0]           line_cnt,
  output logic [ADDR_W-1:0]           ram_addr,
  output logic [$clog2(ROM_BYTES)-1:0] rom_addr,
  output logic                        steal,
  output vreq_t                       steal_req,
  output logic [BYTE_W-1:0]           cpu_rdata
);
  localparam int ROM_AW = $clog2(ROM_BYTES);
  localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_BYTES);
  localparam logic [ADDR_W:0] RAM_LIM = (ADDR_W+1)'(RAM_TOP);

  logic              is_read;
  logic              in_rom;
  logic              mirror;
  logic              ram_hit;
  logic [BYTE_W-1:0] ram_byte;
  logic [BYTE_W-1:0] rdata_nxt;

  always_comb begin
    is_read  = mem_req & rd_req;
    in_rom   = {1'b0, cpu_addr} < ROM_LIM;
    mirror   = opfetch & cpu_addr[ADDR_W-1] & ~in_rom;
    ram_addr = mirror ? {1'b0, cpu_addr[ADDR_W-2:0]} : cpu_addr;
    ram_hit  = {1'b0, ram_addr} < RAM_LIM;
    ram_byte = ram_hit ? ram_rdata : {BYTE_W{1'b1}};
    rom_addr = cpu_addr[ROM_AW-1:0];
    steal    = is_read & mirror & ~ram_byte[PASS_BIT];
    steal_req.valid = 1'b1;
    steal_req.inv   = ~ram_byte[INV_BIT];
    steal_req.chr   = ram_byte[CHR_W-1:0];
    steal_req.line  = line_cnt;
    if (in_rom)     rdata_nxt = rom_rdata;
    else if (steal) rdata_nxt = '0;
    else            rdata_nxt = ram_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)          cpu_rdata <= '0;
    else if (is_read) cpu_rdata <= rdata_nxt;
  end

  assert_rom_served_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && rd_req && ({1'b0, cpu_addr} < ROM_LIM)) |=> cpu_rdata == $past(rom_rdata));

  assert_nop_on_steal_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && rd_req && opfetch && cpu_addr[ADDR_W-1] && !in_rom &&
     ({2'b0, cpu_addr[ADDR_W-2:0]} < RAM_LIM) && !ram_rdata[PASS_BIT]) |=> cpu_rdata == '0);

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && rd_req) |=> $stable(cpu_rdata));
endmodule

// File: rtl/glyph_fetch.sv
module glyph_fetch
  import charsteal_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 8192,
  parameter int RAM_TOP   = 17408
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic                        refresh_now,
  input  logic                        steal,
  input  vreq_t                       steal_req,
  input  logic [BYTE_W-1:0]           ram_rdata,
  input  logic [BYTE_W-1:0]           rom_rdata,
  output logic [$clog2(ROM_BYTES)-1:0] glyph_rom_addr,
  output logic                        glyph_sel,
  output logic                        irq_n,
  output logic                        load,
  output logic [BYTE_W-1:0]           load_byte
);
  localparam int ROM_AW = $clog2(ROM_BYTES);
  localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_BYTES);
  localparam logic [ADDR_W:0] RAM_LIM = (ADDR_W+1)'(RAM_TOP);

  vreq_t             pend;
  logic [ADDR_W-1:0] glyph_addr;
  logic              glyph_in_rom;
  logic [BYTE_W-1:0] raw_byte;

  always_comb begin
    glyph_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}
               | ADDR_W'({pend.chr, pend.line});
    glyph_in_rom   = {1'b0, glyph_addr} < ROM_LIM;
    glyph_rom_addr = glyph_addr[ROM_AW-1:0];
    glyph_sel      = refresh_now & pend.valid & glyph_in_rom;
    load           = refresh_now & pend.valid;
    if (glyph_in_rom)                     raw_byte = rom_rdata;
    else if ({1'b0, cpu_addr} < RAM_LIM)  raw_byte = ram_rdata;
    else                                  raw_byte = {BYTE_W{1'b1}};
    load_byte = raw_byte ^ {BYTE_W{pend.inv}};
  end

  always_ff @(posedge clk) begin
    if (rst)        pend <= '0;
    else if (steal) pend <= steal_req;
    else if (load)  pend.valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)              irq_n <= 1'b1;
    else if (refresh_now) irq_n <= cpu_addr[IRQ_BIT];
  end

  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (rst)
    refresh_now |=> irq_n == $past(cpu_addr[IRQ_BIT]));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !refresh_now |=> $stable(irq_n));

  assert_single_use_R10: assert property (@(posedge clk) disable iff (rst)
    (load && !steal) |=> !pend.valid);
endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter
  import charsteal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              pix_out
);
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W:0]    remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      remain  <= '0;
      pix_out <= 1'b0;
    end else if (load) begin
      pix_out <= load_byte[BYTE_W-1];
      shreg   <= {load_byte[BYTE_W-2:0], 1'b0};
      remain  <= (CNT_W+1)'(BYTE_W-1);
    end else if (remain != '0) begin
      pix_out <= shreg[BYTE_W-1];
      shreg   <= {shreg[BYTE_W-2:0], 1'b0};
      remain  <= remain - 1'b1;
    end else begin
      pix_out <= 1'b0;
    end
  end

  assert_load_first_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> pix_out == $past(load_byte[BYTE_W-1]));

  assert_dark_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (remain == '0 && !load) |=> !pix_out);

  assert_count_range_R11: assert property (@(posedge clk) disable iff (rst)
    remain < (CNT_W+1)'(BYTE_W));
endmodule

// File: rtl/charsteal_video.sv
module charsteal_video
  import charsteal_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 8192,
  parameter int RAM_TOP   = 17408
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic                         mem_req,
  input  logic                         rd_req,
  input  logic                         opfetch,
  input  logic                         refresh,
  input  logic [7:0]                   ram_rdata,
  input  logic [7:0]                   rom_rdata,
  input  logic [2:0]                   line_cnt,
  output logic [7:0]                   cpu_rdata,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [$clog2(ROM_BYTES)-1:0] rom_addr,
  output logic                         irq_n,
  output logic                         pix_out
);
  localparam int ROM_AW = $clog2(ROM_BYTES);

  logic              steal;
  vreq_t             steal_req;
  logic [ROM_AW-1:0] cpu_rom_addr;
  logic [ROM_AW-1:0] glyph_rom_addr;
  logic              glyph_sel;
  logic              load;
  logic [BYTE_W-1:0] load_byte;
  logic              refresh_now;

  assign refresh_now = mem_req & refresh;

  steal_decode #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .RAM_TOP(RAM_TOP)) u_decode (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mem_req(mem_req), .rd_req(rd_req),
    .opfetch(opfetch), .ram_rdata(ram_rdata), .rom_rdata(rom_rdata), .line_cnt(line_cnt),
    .ram_addr(mem_addr), .rom_addr(cpu_rom_addr), .steal(steal), .steal_req(steal_req),
    .cpu_rdata(cpu_rdata)
  );

  glyph_fetch #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .RAM_TOP(RAM_TOP)) u_glyph (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .refresh_now(refresh_now), .steal(steal),
    .steal_req(steal_req), .ram_rdata(ram_rdata), .rom_rdata(rom_rdata),
    .glyph_rom_addr(glyph_rom_addr), .glyph_sel(glyph_sel), .irq_n(irq_n),
    .load(load), .load_byte(load_byte)
  );

  pixel_shifter u_shift (
    .clk(clk), .rst(rst), .load(load), .load_byte(load_byte), .pix_out(pix_out)
  );

  assign rom_addr = glyph_sel ? glyph_rom_addr : cpu_rom_addr;
endmodule

// File: tb/charsteal_video_tb.sv
module charsteal_video_tb;
  localparam int ROMB = 2048;
  localparam int RAMT = 16'h5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        mem_req = 0, rd_req = 0, opfetch = 0, refresh = 0;
  logic [7:0]  ram_rdata, rom_rdata;
  logic [2:0]  line_cnt = '0;
  logic [7:0]  cpu_rdata;
  logic [15:0] mem_addr;
  logic [10:0] rom_addr;
  logic        irq_n, pix_out;

  int errors = 0, checks = 0;
  bit done = 0;

  // expected-model state
  bit         e_pend = 0, e_inv = 0;
  logic [5:0] e_chr = '0;
  logic [2:0] e_line = '0;
  logic [7:0] e_sh = '0;
  int         e_left = 0;
  bit         e_ovr = 0;

  always #4 clk = ~clk;

  charsteal_video #(.ADDR_W(16), .ROM_BYTES(ROMB), .RAM_TOP(RAMT)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mem_req(mem_req), .rd_req(rd_req),
    .opfetch(opfetch), .refresh(refresh), .ram_rdata(ram_rdata), .rom_rdata(rom_rdata),
    .line_cnt(line_cnt), .cpu_rdata(cpu_rdata), .mem_addr(mem_addr), .rom_addr(rom_addr),
    .irq_n(irq_n), .pix_out(pix_out)
  );

  function automatic logic [7:0] rom_fn(logic [15:0] a);
    return (a[7:0] * 8'd13) ^ {a[10:8], 5'b10101};
  endfunction
  function automatic logic [7:0] ram_fn(logic [15:0] a);
    return a[7:0] ^ a[14:7] ^ 8'h5A;
  endfunction

  assign rom_rdata = rom_fn({5'b0, rom_addr});
  assign ram_rdata = ram_fn(mem_addr);

  function automatic logic [7:0] ram_or_open(logic [15:0] a);
    return (a < RAMT) ? ram_fn(a) : 8'hFF;
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    mem_req = 0; rd_req = 0; opfetch = 0; refresh = 0;
  endtask

  // compare pix_out with the model after each clock
  task automatic px_step();
    logic e;
    if (e_left > 0) begin
      e = e_sh[7]; e_sh = {e_sh[6:0], 1'b0}; e_left--;
    end else begin
      e = 1'b0; e_ovr = 0;
    end
    check(pix_out == e, e_ovr ? "R11 pixel after override" : "R10 pixel order",
          {15'b0, pix_out}, {15'b0, e});
  endtask

  task automatic do_idle(int n);
    for (int i = 0; i < n; i++) begin
      idle_bus();
      @(negedge clk);
      px_step();
    end
  endtask

  task automatic do_read(logic [15:0] a, bit m1, logic [2:0] ln);
    logic [7:0] exp, v;
    logic [15:0] ra;
    bit mir;
    string tag;
    mem_req = 1; rd_req = 1; opfetch = m1; refresh = 0; cpu_addr = a; line_cnt = ln;
    if (a < ROMB) begin
      exp = rom_fn(a & 16'h07FF); tag = "R2 ROM read";
    end else begin
      mir = m1 && a[15];
      ra  = mir ? (a & 16'h7FFF) : a;
      v   = ram_or_open(ra);
      if (mir && !v[6]) begin
        exp = 8'h00; tag = "R5 stolen fetch NOP";
        e_pend = 1; e_chr = v[5:0]; e_inv = !v[7]; e_line = ln;
      end else begin
        exp = v; tag = mir ? "R4 mirrored pass" : "R3 RAM read";
      end
    end
    @(negedge clk);
    idle_bus();
    check(cpu_rdata == exp, tag, {8'b0, cpu_rdata}, {8'b0, exp});
    px_step();
  endtask

  task automatic do_refresh(logic [15:0] a);
    logic [15:0] g;
    logic [7:0]  b;
    mem_req = 1; rd_req = 0; opfetch = 0; refresh = 1; cpu_addr = a;
    @(negedge clk);
    idle_bus();
    check(irq_n == a[6], "R9 irq from refresh bit 6", {15'b0, irq_n}, {15'b0, a[6]});
    if (e_pend) begin
      // R6: glyph = refresh high byte | chr<<3 | line
      g = (a & 16'hFF00) | {7'b0, e_chr, e_line};
      if (g < ROMB) b = rom_fn(g & 16'h07FF);
      else          b = ram_or_open(a);     // R7
      if (e_inv) b = ~b;                     // R8
      e_ovr = (e_left > 0);
      e_sh = b; e_left = 8; e_pend = 0;
    end
    px_step();
  endtask

  function automatic logic [15:0] find_ram(bit b6, bit b7, logic [15:0] start);
    for (int i = 0; i < 8192; i++) begin
      logic [15:0] a = start + 16'(i);
      logic [7:0] v = ram_fn(a);
      if (a >= ROMB && a < RAMT && v[6] == b6 && v[7] == b7) return a;
    end
    return start;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(cpu_rdata == 8'h00, "R1 reset cpu_rdata", {8'b0, cpu_rdata}, 16'h0);
    check(irq_n == 1'b1, "R1 reset irq_n", {15'b0, irq_n}, 16'h1);
    check(pix_out == 1'b0, "R1 reset pix_out", {15'b0, pix_out}, 16'h0);
    do_refresh(16'h0040);
    do_idle(2);

    // directed R2 / R3 / R4
    do_read(16'h0123, 1, 3'd0);
    do_read(16'h0123, 0, 3'd0);
    do_read(16'h0923, 0, 3'd0);
    do_read(16'h8100, 0, 3'd0);   // R3: no mirror without opfetch, above RAM top
    do_read(16'hD800, 1, 3'd0);   // R4: alias 0x5800 has no RAM -> 0xFF passes
    a = find_ram(1, 1, 16'h1000);
    do_read(a | 16'h8000, 1, 3'd0);  // R4 pass unchanged

    // R5/R6/R8 glyph in ROM, both polarities
    a = find_ram(0, 1, 16'h1000);
    do_read(a | 16'h8000, 1, 3'd5);
    do_refresh(16'h0341);
    do_idle(9);
    a = find_ram(0, 0, 16'h2000);
    do_read(a | 16'h8000, 1, 3'd2);
    do_idle(2);                    // pending survives idle cycles
    do_refresh(16'h0500);
    do_idle(9);

    // R7 glyph outside ROM: RAM byte at refresh address, then open bus
    a = find_ram(0, 1, 16'h3000);
    do_read(a | 16'h8000, 1, 3'd1);
    do_refresh(16'h3C41);
    do_idle(9);
    a = find_ram(0, 0, 16'h3000);
    do_read(a | 16'h8000, 1, 3'd7);
    do_refresh(16'h7F00);
    do_idle(9);

    // R11 override mid-shift
    a = find_ram(0, 1, 16'h1100);
    do_read(a | 16'h8000, 1, 3'd4);
    do_refresh(16'h0200);
    do_idle(2);
    a = find_ram(0, 0, 16'h2200);
    do_read(a | 16'h8000, 1, 3'd6);
    do_refresh(16'h0600);
    do_idle(9);

    // R10 second refresh without a new steal shows nothing
    do_refresh(16'h0600);
    do_idle(3);

    // R1 reset with a fetch pending drops it
    a = find_ram(0, 1, 16'h1200);
    do_read(a | 16'h8000, 1, 3'd0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    e_pend = 0; e_left = 0;
    check(irq_n == 1'b1 && cpu_rdata == 8'h00, "R1 reset clears outputs",
          {7'b0, irq_n, cpu_rdata}, 16'h0100);
    do_refresh(16'h0100);
    do_idle(3);

    // constrained random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1500; i++) begin
      int kind = int'($urandom % 10);
      logic [15:0] ra = 16'($urandom);
      if (kind < 5) begin
        if ($urandom % 3 == 0) ra = ra & 16'h87FF;
        do_read(ra, bit'($urandom % 4 != 0), 3'($urandom));
      end else if (kind < 8) begin
        if ($urandom % 2 == 0) ra = ra & 16'h07FF;
        do_refresh(ra);
      end else begin
        do_idle(1);
      end
    end
    do_idle(10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule